// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for four-beat burst accesses. A new burst begins when one of two load strobes is seen at a rising clock edge. One strobe is meant for a processor and only counts while the first chip select is active. The other is meant for a cache controller and loads whatever the chip select is doing. The whole input address is captured on that edge. Its upper bits are then held for the rest of the burst, and its two low bits become the starting word.

A two-bit beat counter moves forward by one on each edge where the advance input is high, and it wraps after the fourth beat. The low two address bits come from the starting word and the beat number. The ordering input chooses how they are combined. In interleaved ordering the starting word is exclusive-ORed with the beat number. In linear ordering the beat number is added to the starting word, modulo four. The ordering input is read live, so it is expected to be held static during a burst.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, addrOut is all zeros and beatIdx is 0.
- R2: When ctrlStrobe is high at a clock edge, addrIn is captured whatever the value of chipSel. After that edge, addrOut equals the captured addrIn and beatIdx is 0.
- R3: procStrobe loads addrIn only when chipSel is 1. With chipSel at 0 and no other strobe, addrOut and beatIdx keep their values.
- R4: With no load strobe, each edge with advance at 1 raises beatIdx by one. An edge with advance at 0 leaves beatIdx and addrOut unchanged.
- R5: With linearMode at 0 (interleaved), addrOut[1:0] equals the captured start bits XOR beatIdx. For a start of 01 the order is 01, 00, 11, 10.
- R6: With linearMode at 1 (linear), addrOut[1:0] equals the captured start bits plus beatIdx, modulo 4. For a start of 01 the order is 01, 10, 11, 00.
- R7: A load strobe and advance on the same edge perform the load. beatIdx becomes 0, not 1.
- R8: addrOut[ADDR_W-1:2] stays at the captured value until the next load, whatever addrIn does.
- R9: The fourth advance after a load wraps beatIdx to 0 and brings addrOut back to the starting address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| procStrobe | input | 1 | Processor load strobe, qualified by chipSel |
| ctrlStrobe | input | 1 | Controller load strobe, unqualified |
| chipSel | input | 1 | First chip select; gates procStrobe only |
| advance | input | 1 | Step to the next beat |
| linearMode | input | 1 | 1 = linear ordering, 0 = interleaved ordering |
| addrIn | input | ADDR_W | Start address sampled on a load |
| addrOut | output | ADDR_W | Current burst address |
| beatIdx | output | 2 | Position within the burst (0 to 3) |

## Verification
A corrupted beat counter is visible through beatIdx, and through addrOut[1:0], on the first edge after the fault. A corrupted start register leaves beatIdx correct but puts addrOut[1:0] off the expected ordering at once. A captured upper field that drifts shows in addrOut[ADDR_W-1:2] on the edge where it changes, because the bench changes addrIn between loads. A wrong strobe qualifier shows at the edge after the strobe, as a load that should not have happened or one that is missing.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic load;  // capture a new start address
    logic step;  // move to the next beat
  } burstCtl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              chipSel,
  input  logic              advance,
  output burstCtl_t         ctl,
  output logic [BEAT_W-1:0] beat
);
  logic procLoad;
  logic anyLoad;

  // The processor strobe only counts while chip select is active
  assign procLoad = procStrobe & chipSel;
  assign anyLoad  = procLoad | ctrlStrobe;

  always_comb begin
    ctl.load = anyLoad;
    ctl.step = advance & ~anyLoad;  // a load overrides advance
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beat <= '0;
    end else if (ctl.load) begin
      beat <= '0;
    end else if (ctl.step) begin
      beat <= beat + 1'b1;  // two bits, so it wraps after four beats
    end
  end

  // R7: a load on the same edge as advance restarts at beat 0
  a_r7_load_first: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStrobe || (procStrobe && chipSel)) |=> beat == '0);

  // R4: advance without a load moves exactly one beat forward
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !ctrlStrobe && !procStrobe) |=> beat == $past(beat) + 1'b1);

  // R4: no advance and no load means the beat holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !ctrlStrobe && !procStrobe) |=> $stable(beat));

  // R3: a processor strobe with chip select low changes nothing
  a_r3_gated: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe && !chipSel && !ctrlStrobe && !advance) |=> $stable(beat));
endmodule

// File: rtl/burst_path.sv
module burst_path
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic [BEAT_W-1:0] beat,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   baseHi;
  logic [BEAT_W-1:0] startLo;
  logic [BEAT_W-1:0] seqXor;
  logic [BEAT_W-1:0] seqAdd;
  logic [BEAT_W-1:0] lowOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHi  <= '0;
      startLo <= '0;
    end else if (ctl.load) begin
      baseHi  <= addrIn[ADDR_W-1:BEAT_W];
      startLo <= addrIn[BEAT_W-1:0];
    end
  end

  // Both orderings are formed in parallel; the ordering input picks one
  assign seqXor = startLo ^ beat;
  assign seqAdd = startLo + beat;
  assign lowOut = linearMode ? seqAdd : seqXor;
  assign addrOut = {baseHi, lowOut};

  // R8: the upper field only moves on a load
  a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(addrOut[ADDR_W-1:BEAT_W]));

  // R2: a load presents the sampled address on the next edge
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> addrOut == $past(addrIn));

  // R5: in interleaved order, odd beats flip bit 0 and keep bit 1
  a_r5_interleave_bit: assert property (@(posedge clk) disable iff (!rstN)
    (!linearMode && beat == 2'd1) |-> (addrOut[1] == startLo[1] && addrOut[0] != startLo[0]));

  // R6: in linear order, beat 2 flips bit 1 and keeps bit 0
  a_r6_linear_half: assert property (@(posedge clk) disable iff (!rstN)
    (linearMode && beat == 2'd2) |-> (addrOut[0] == startLo[0] && addrOut[1] != startLo[1]));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobe,
  input  logic              ctrlStrobe,
  input  logic              chipSel,
  input  logic              advance,
  input  logic              linearMode,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        beatIdx
);
  burstCtl_t         ctl;
  logic [BEAT_W-1:0] beat;

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .procStrobe (procStrobe),
    .ctrlStrobe (ctrlStrobe),
    .chipSel    (chipSel),
    .advance    (advance),
    .ctl        (ctl),
    .beat       (beat)
  );

  burst_path #(.ADDR_W(ADDR_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .beat       (beat),
    .linearMode (linearMode),
    .addrIn     (addrIn),
    .addrOut    (addrOut)
  );

  assign beatIdx = beat;

  // R9: the fourth step from beat 3 lands on beat 0 again
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (beatIdx == 2'd3 && advance && !ctrlStrobe && !procStrobe) |=> beatIdx == 2'd0);
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int PERIOD = 10;
  localparam int AW = 17;

  typedef struct packed {
    logic          proc;
    logic          ctrl;
    logic          cs;
    logic          adv;
    logic          lin;
    logic [AW-1:0] addr;
    logic [AW-1:0] expAddr;
    logic [1:0]    expBeat;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 17'h12345, 17'h12345, 2'd0, 4'd2}, // R2 controller load, cs low
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h12344, 2'd1, 4'd5}, // R5 01^1=00
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h12347, 2'd2, 4'd5}, // R5 01^2=11
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h12346, 2'd3, 4'd5}, // R5 01^3=10
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h12345, 2'd0, 4'd9}, // R9 wrap
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 17'h0ABCD, 17'h0ABCD, 2'd0, 4'd2}, // R2 reload
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h0ABCE, 2'd1, 4'd6}, // R6 01+1
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h0ABCF, 2'd2, 4'd6}, // R6 01+2
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h0ABCC, 2'd3, 4'd6}, // R6 01+3 mod 4
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 17'h1FFFF, 17'h0ABCC, 2'd3, 4'd8}, // R8 R4 hold
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 17'h00002, 17'h0ABCC, 2'd3, 4'd3}, // R3 gated strobe
    '{1'b1,1'b0,1'b1,1'b1,1'b0, 17'h00002, 17'h00002, 2'd0, 4'd7}, // R7 load beats advance
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 17'h00000, 17'h00003, 2'd1, 4'd4}, // R4 10^1=11
    '{1'b0,1'b0,1'b0,1'b1,1'b1, 17'h00000, 17'h00000, 2'd2, 4'd6}  // R6 10+2=00
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          procStrobe = 1'b0, ctrlStrobe = 1'b0, chipSel = 1'b0;
  logic          advance = 1'b0, linearMode = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic [1:0]    beatIdx;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .chipSel(chipSel), .advance(advance), .linearMode(linearMode),
    .addrIn(addrIn), .addrOut(addrOut), .beatIdx(beatIdx)
  );

  task automatic check(input string tag, input logic [AW-1:0] expA, input logic [1:0] expB);
    checks++;
    if (addrOut !== expA || beatIdx !== expB) begin
      errors++;
      $display("FAIL %s: addrOut=%h beatIdx=%0d expected addrOut=%h beatIdx=%0d",
               tag, addrOut, beatIdx, expA, expB);
    end
  endtask

  task automatic drive(input logic p, input logic c, input logic s,
                       input logic a, input logic l, input logic [AW-1:0] ad);
    @(negedge clk);
    procStrobe = p; ctrlStrobe = c; chipSel = s; advance = a; linearMode = l; addrIn = ad;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  initial begin
    #(PERIOD*3);
    check("R1 reset", '0, 2'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].proc, VECS[i].ctrl, VECS[i].cs, VECS[i].adv, VECS[i].lin, VECS[i].addr);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].expAddr, VECS[i].expBeat);
    end

    // R6: linear order from start 11 wraps through 00
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 17'h15557);
    check("R6 start 11", 17'h15557, 2'd0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 17'h0);
    check("R6 11+1", 17'h15554, 2'd1);

    // R4: advance held low over several edges
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 17'h0F0F0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 17'h0F0F0);
    check("R4 idle hold", 17'h15554, 2'd1);

    // R1: reset in the middle of a burst
    @(negedge clk);
    rstN = 1'b0;
    #(PERIOD/4);
    check("R1 mid-burst reset", '0, 2'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R3: processor strobe with chip select loads
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 17'h00011);
    check("R3 qualified proc load", 17'h00011, 2'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD*200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule